// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Termination Control

This block runs one external bus cycle at a time on behalf of the internal core. When idle, it takes a request carrying an address, a read/write flag, a transfer code and a transfer size, and captures them. From the next cycle it presents them on the bus pins, together with an optional chip-select, a read-only output enable and an optional show-cycle strobe. The cycle then waits for a terminating response. A normal acknowledge can come from the external pin or from an internal source. An error acknowledge can come from the external pin, from an internal source, or from the built-in bus monitor when no response arrives in time.

When the cycle terminates, the core receives a one-cycle completion pulse with an error flag, and the block is idle again in the following cycle. If the core abandons a cycle in flight, the bus side still runs to its normal end with all pins driven, but no completion is reported. While emulation or master mode is active, a 2-bit emulation select goes out with each cycle. It marks the access as a port register, a module register, another internal location or a purely external location, so that outside hardware can follow the traffic.

Top module: `ebus_term_ctrl`

## Requirements
- R1: A request seen while idle is captured. From the next cycle until the terminating cycle inclusive, busy_o is 1 and bus_addr_o, bus_rw_o, bus_tc_o and bus_tsiz_o show the captured values and do not change.
- R2: A cycle in which ta_ext_i or ta_int_i is 1, with no error source active, terminates the bus cycle. In the following cycle, done_o is 1 and err_o is 0.
- R3: A cycle in which tea_ext_i or tea_int_i is 1 terminates the bus cycle. In the following cycle, done_o is 1 and err_o is 1.
- R4: When a normal acknowledge and any error source are active in the same cycle, the termination is an error (err_o is 1).
- R5: With bmon_en_i at 1 and bmon_limit_i equal to N (N > 0) at request time, and no earlier response, bmon_to_o is 1 in the Nth busy cycle and the cycle ends with an error. With bmon_en_i at 0 or N equal to 0, bmon_to_o stays 0.
- R6: An abort_i pulse in any busy cycle, including the terminating one, leaves the bus pins driven and the termination timing unchanged. done_o and err_o then stay 0 for that cycle.
- R7: bus_rw_o is 1 for a read. bus_oe_o is 1 only during busy cycles of a read. bus_cs_o and bus_shs_o are 1 during busy cycles only when cs_use_i or shs_use_i, respectively, was 1 at request time.
- R8: During busy cycles with emu_mode_i or master_mode_i at 1 at request time, cse_o takes one of these values: 2'b10 for an address in 0xC000-0xC03F (port registers, low 6 bits select the register); 2'b11 for any other address in 0xC000-0xCFFF (module registers); 2'b01 for 0x0000-0x7FFF (other internal); 2'b00 otherwise. With neither mode, and in all non-busy cycles, cse_o is 2'b00.
- R9: done_o lasts exactly one cycle and the block is idle in the next cycle. A request held during the completion cycle is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Cycle request from the core |
| addr_i | input | 16 | Request address |
| rd_i | input | 1 | 1 = read, 0 = write |
| tc_i | input | 3 | Transfer code |
| tsiz_i | input | 2 | Transfer size |
| cs_use_i | input | 1 | Cycle uses a chip-select |
| shs_use_i | input | 1 | Cycle uses the show-cycle strobe |
| emu_mode_i | input | 1 | Emulation mode active |
| master_mode_i | input | 1 | Master mode active |
| abort_i | input | 1 | Core abandons the current cycle |
| ta_ext_i | input | 1 | External transfer acknowledge |
| ta_int_i | input | 1 | Internal transfer acknowledge |
| tea_ext_i | input | 1 | External transfer error acknowledge |
| tea_int_i | input | 1 | Internal transfer error acknowledge |
| bmon_en_i | input | 1 | Bus monitor enable, sampled at request |
| bmon_limit_i | input | 8 | Bus monitor limit in cycles, sampled at request |
| bus_addr_o | output | 16 | Address pins |
| bus_rw_o | output | 1 | Read/write pin |
| bus_tc_o | output | 3 | Transfer code pins |
| bus_tsiz_o | output | 2 | Transfer size pins |
| bus_cs_o | output | 1 | Chip-select |
| bus_oe_o | output | 1 | Output enable |
| bus_shs_o | output | 1 | Show-cycle strobe |
| cse_o | output | 2 | Emulation access-class select |
| busy_o | output | 1 | A bus cycle is in progress |
| done_o | output | 1 | Completion pulse to the core |
| err_o | output | 1 | Completion ended in error |
| bmon_to_o | output | 1 | Bus monitor timed out this cycle |

## Verification
Three things can meet in one busy cycle: a normal acknowledge, an error acknowledge and a monitor timeout. A fourth, a core abort, can coincide with the terminating cycle. The bench sweeps every arrival cycle from one to three for each acknowledge, every monitor limit up to four, and the monitor enable, including runs where two or three sources hit the same cycle. It computes the terminating cycle as the earliest arrival and predicts an error when an error source is no later than the normal one. Aborts are also placed on the terminating cycle, to check that completion is withheld while the pins stay driven.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_DONE = 2'd2
   } ebus_state_e;

   localparam logic [1:0] CSE_EXT  = 2'b00;
   localparam logic [1:0] CSE_INT  = 2'b01;
   localparam logic [1:0] CSE_PORT = 2'b10;
   localparam logic [1:0] CSE_MOD  = 2'b11;
endpackage

// File: rtl/ebus_emu_sel.sv
module ebus_emu_sel #(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] PORT_BASE  = 16'hC000,
   parameter int                PORT_LOW_W = 6,
   parameter logic [ADDR_W-1:0] MOD_BASE   = 16'hC000,
   parameter int                MOD_LOW_W  = 12,
   parameter logic [ADDR_W-1:0] INT_BASE   = 16'h0000,
   parameter int                INT_LOW_W  = 15
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              mode_on_i,
   output logic [1:0]        cse_o
);
   import ebus_pkg::*;

   if (PORT_LOW_W > MOD_LOW_W) begin : g_bad_nest
      $error("port window must lie inside module window");
   end
   if (MOD_LOW_W >= ADDR_W || INT_LOW_W >= ADDR_W || PORT_LOW_W < 1) begin : g_bad_w
      $error("window widths out of range");
   end

   logic hit_port, hit_mod, hit_int;

   assign hit_port = addr_i[ADDR_W-1:PORT_LOW_W] == PORT_BASE[ADDR_W-1:PORT_LOW_W];
   assign hit_mod  = addr_i[ADDR_W-1:MOD_LOW_W]  == MOD_BASE[ADDR_W-1:MOD_LOW_W];
   assign hit_int  = addr_i[ADDR_W-1:INT_LOW_W]  == INT_BASE[ADDR_W-1:INT_LOW_W];

   always_comb begin
      cse_o = CSE_EXT;
      if (mode_on_i) begin
         if (hit_port)     cse_o = CSE_PORT;
         else if (hit_mod) cse_o = CSE_MOD;
         else if (hit_int) cse_o = CSE_INT;
      end
   end
endmodule

// File: rtl/ebus_bus_mon.sv
module ebus_bus_mon #(
   parameter int TMO_W   = 8,
   parameter bit PRESENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             active_i,
   input  logic             en_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             tmo_o
);
   if (TMO_W < 1 || TMO_W > 32) begin : g_bad_w
      $error("TMO_W out of range");
   end

   if (PRESENT) begin : g_mon
      logic [TMO_W-1:0] cnt_q;
      logic             armed_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
         end else if (start_i) begin
            cnt_q   <= limit_i;
            armed_q <= en_i && (limit_i != '0);
         end else if (active_i && cnt_q != '0) begin
            cnt_q   <= cnt_q - 1'b1;
         end
      end

      assign tmo_o = active_i && armed_q && (cnt_q == TMO_W'(1));
   end else begin : g_no_mon
      logic unused_w;
      assign unused_w = ^{clk, rst_n, start_i, active_i, en_i, limit_i};
      assign tmo_o = 1'b0;
   end
endmodule

// File: rtl/ebus_term_arb.sv
module ebus_term_arb (
   input  logic ta_ext_i,
   input  logic ta_int_i,
   input  logic tea_ext_i,
   input  logic tea_int_i,
   input  logic tmo_i,
   output logic term_o,
   output logic err_o
);
   logic any_err, any_ok;

   assign any_err = tea_ext_i | tea_int_i | tmo_i;
   assign any_ok  = ta_ext_i | ta_int_i;
   assign term_o  = any_err | any_ok;
   assign err_o   = any_err;
endmodule

// File: rtl/ebus_term_ctrl.sv
module ebus_term_ctrl #(
   parameter int                ADDR_W     = 16,
   parameter int                TC_W       = 3,
   parameter int                SIZE_W     = 2,
   parameter int                TMO_W      = 8,
   parameter bit                HAS_BMON   = 1'b1,
   parameter logic [ADDR_W-1:0] PORT_BASE  = 16'hC000,
   parameter int                PORT_LOW_W = 6,
   parameter logic [ADDR_W-1:0] MOD_BASE   = 16'hC000,
   parameter int                MOD_LOW_W  = 12,
   parameter logic [ADDR_W-1:0] INT_BASE   = 16'h0000,
   parameter int                INT_LOW_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic [TC_W-1:0]   tc_i,
   input  logic [SIZE_W-1:0] tsiz_i,
   input  logic              cs_use_i,
   input  logic              shs_use_i,
   input  logic              emu_mode_i,
   input  logic              master_mode_i,
   input  logic              abort_i,
   input  logic              ta_ext_i,
   input  logic              ta_int_i,
   input  logic              tea_ext_i,
   input  logic              tea_int_i,
   input  logic              bmon_en_i,
   input  logic [TMO_W-1:0]  bmon_limit_i,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_rw_o,
   output logic [TC_W-1:0]   bus_tc_o,
   output logic [SIZE_W-1:0] bus_tsiz_o,
   output logic              bus_cs_o,
   output logic              bus_oe_o,
   output logic              bus_shs_o,
   output logic [1:0]        cse_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              bmon_to_o
);
   import ebus_pkg::*;

   if (ADDR_W < 8 || TC_W < 1 || SIZE_W < 1) begin : g_bad_w
      $error("bus field widths out of range");
   end

   ebus_state_e       state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rw_q;
   logic [TC_W-1:0]   tc_q;
   logic [SIZE_W-1:0] tsiz_q;
   logic              cs_use_q;
   logic              shs_use_q;
   logic [1:0]        cse_q;
   logic              abort_q;
   logic              done_q;
   logic              err_q;

   logic       start_w, active_w, term_w, term_err_w, tmo_w, abort_now_w;
   logic [1:0] cse_w;

   assign start_w     = (state_q == ST_IDLE) && req_i;
   assign active_w    = (state_q == ST_ACT);
   assign abort_now_w = abort_q | abort_i;

   ebus_emu_sel #(
      .ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE), .PORT_LOW_W(PORT_LOW_W),
      .MOD_BASE(MOD_BASE), .MOD_LOW_W(MOD_LOW_W),
      .INT_BASE(INT_BASE), .INT_LOW_W(INT_LOW_W)
   ) u_emu_sel (
      .addr_i    (addr_i),
      .mode_on_i (emu_mode_i | master_mode_i),
      .cse_o     (cse_w)
   );

   ebus_bus_mon #(
      .TMO_W(TMO_W), .PRESENT(HAS_BMON)
   ) u_bus_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_w),
      .active_i (active_w),
      .en_i     (bmon_en_i),
      .limit_i  (bmon_limit_i),
      .tmo_o    (tmo_w)
   );

   ebus_term_arb u_term_arb (
      .ta_ext_i  (ta_ext_i),
      .ta_int_i  (ta_int_i),
      .tea_ext_i (tea_ext_i),
      .tea_int_i (tea_int_i),
      .tmo_i     (tmo_w),
      .term_o    (term_w),
      .err_o     (term_err_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         rw_q      <= 1'b0;
         tc_q      <= '0;
         tsiz_q    <= '0;
         cs_use_q  <= 1'b0;
         shs_use_q <= 1'b0;
         cse_q     <= CSE_EXT;
         abort_q   <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               done_q <= 1'b0;
               err_q  <= 1'b0;
               if (start_w) begin
                  state_q   <= ST_ACT;
                  addr_q    <= addr_i;
                  rw_q      <= rd_i;
                  tc_q      <= tc_i;
                  tsiz_q    <= tsiz_i;
                  cs_use_q  <= cs_use_i;
                  shs_use_q <= shs_use_i;
                  cse_q     <= cse_w;
                  abort_q   <= 1'b0;
               end
            end
            ST_ACT: begin
               abort_q <= abort_now_w;
               if (term_w) begin
                  state_q <= ST_DONE;
                  done_q  <= !abort_now_w;
                  err_q   <= term_err_w && !abort_now_w;
               end
            end
            ST_DONE: begin
               state_q <= ST_IDLE;
               done_q  <= 1'b0;
               err_q   <= 1'b0;
               abort_q <= 1'b0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_addr_o = addr_q;
   assign bus_rw_o   = rw_q;
   assign bus_tc_o   = tc_q;
   assign bus_tsiz_o = tsiz_q;
   assign bus_cs_o   = active_w && cs_use_q;
   assign bus_oe_o   = active_w && rw_q;
   assign bus_shs_o  = active_w && shs_use_q;
   assign cse_o      = active_w ? cse_q : CSE_EXT;
   assign busy_o     = active_w;
   assign done_o     = done_q;
   assign err_o      = err_q;
   assign bmon_to_o  = tmo_w;
endmodule

// File: rtl/ebus_term_ctrl_chk.sv
module ebus_term_ctrl_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic              ta_ext_i,
   input logic              ta_int_i,
   input logic              tea_ext_i,
   input logic              tea_int_i,
   input logic              abort_i,
   input logic              abort_q,
   input logic              bmon_to_o,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic              bus_oe_o,
   input logic              bus_rw_o,
   input logic [1:0]        cse_o
);
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> $stable(bus_addr_o) && $stable(bus_rw_o)); // R1

   AST_NORMAL_END: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !abort_q && !abort_i && (ta_ext_i || ta_int_i)
      && !tea_ext_i && !tea_int_i && !bmon_to_o |=> done_o && !err_o); // R2

   AST_ERROR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !abort_q && !abort_i && (tea_ext_i || tea_int_i) |=> done_o && err_o); // R4

   AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      bmon_to_o && !abort_q && !abort_i |=> done_o && err_o); // R5

   AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && (abort_q || abort_i) |=> !done_o && !err_o); // R6

   AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe_o |-> busy_o && bus_rw_o); // R7

   AST_CSE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> cse_o == 2'b00); // R8

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o); // R9
endmodule

bind ebus_term_ctrl ebus_term_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/ebus_term_ctrl_tb.sv
module ebus_term_ctrl_tb_top;
   localparam int BIG = 1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 0, rd_i = 0, cs_use_i = 0, shs_use_i = 0;
   logic        emu_mode_i = 0, master_mode_i = 0, abort_i = 0;
   logic        ta_ext_i = 0, ta_int_i = 0, tea_ext_i = 0, tea_int_i = 0;
   logic        bmon_en_i = 0;
   logic [15:0] addr_i = '0;
   logic [2:0]  tc_i = '0;
   logic [1:0]  tsiz_i = '0;
   logic [7:0]  bmon_limit_i = '0;
   logic [15:0] bus_addr_o;
   logic        bus_rw_o, bus_cs_o, bus_oe_o, bus_shs_o;
   logic [2:0]  bus_tc_o;
   logic [1:0]  bus_tsiz_o, cse_o;
   logic        busy_o, done_o, err_o, bmon_to_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   ebus_term_ctrl dut_i (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic int eff(input int k);
      return (k == 0) ? BIG : k;
   endfunction

   function automatic logic [1:0] exp_cse(input logic [15:0] a, input bit mode);
      if (!mode) return 2'b00;
      if (a >= 16'hC000 && a < 16'hC040) return 2'b10;
      if (a >= 16'hC000 && a < 16'hD000) return 2'b11;
      if (a < 16'h8000) return 2'b01;
      return 2'b00;
   endfunction

   task automatic run_one(input logic [15:0] a, input bit rd, input logic [2:0] tc,
                          input logic [1:0] tsiz, input bit csu, input bit shsu,
                          input bit emu, input bit mst, input int ta_k, input int tea_k,
                          input bit ta_int_sel, input bit tea_int_sel, input int lim,
                          input bit en, input int abort_k, input bit req_in_done);
      int tmo_k, term_k, err_k;
      bit exp_err, aborted;
      logic [1:0] ecse;
      tmo_k   = (en && lim > 0) ? lim : 0;
      err_k   = (eff(tea_k) < eff(tmo_k)) ? eff(tea_k) : eff(tmo_k);
      term_k  = (err_k < eff(ta_k)) ? err_k : eff(ta_k);
      exp_err = err_k <= eff(ta_k);
      aborted = (abort_k != 0) && (abort_k <= term_k);
      ecse    = exp_cse(a, emu | mst);
      if (term_k >= BIG) return;

      @(negedge clk);
      req_i = 1; addr_i = a; rd_i = rd; tc_i = tc; tsiz_i = tsiz;
      cs_use_i = csu; shs_use_i = shsu; emu_mode_i = emu; master_mode_i = mst;
      bmon_en_i = en; bmon_limit_i = 8'(lim);
      @(posedge clk);
      for (int k = 1; k <= term_k; k++) begin
         @(negedge clk);
         if (k == 1) begin
            req_i = 0; addr_i = ~a; rd_i = ~rd; tc_i = ~tc; tsiz_i = ~tsiz;
            bmon_limit_i = 8'hFF; bmon_en_i = ~en;
         end
         chk(busy_o === 1'b1, "R1", "busy", 32'(busy_o), 1);
         chk({bus_addr_o, bus_rw_o, bus_tc_o, bus_tsiz_o} === {a, rd, tc, tsiz}, "R1",
             "pins", {bus_addr_o, bus_rw_o, bus_tc_o, bus_tsiz_o}, {a, rd, tc, tsiz});
         chk({bus_oe_o, bus_cs_o, bus_shs_o} === {rd, csu, shsu}, "R7", "oe_cs_shs",
             {bus_oe_o, bus_cs_o, bus_shs_o}, {rd, csu, shsu});
         chk(cse_o === ecse, "R8", "cse", cse_o, ecse);
         chk(bmon_to_o === (k == tmo_k), "R5", "bmon_to", bmon_to_o, (k == tmo_k));
         chk(done_o === 1'b0, "R6", "done_early", done_o, 0);
         ta_ext_i  = (k == ta_k) && !ta_int_sel;
         ta_int_i  = (k == ta_k) && ta_int_sel;
         tea_ext_i = (k == tea_k) && !tea_int_sel;
         tea_int_i = (k == tea_k) && tea_int_sel;
         abort_i   = (k == abort_k);
         @(posedge clk);
      end
      @(negedge clk);
      ta_ext_i = 0; ta_int_i = 0; tea_ext_i = 0; tea_int_i = 0; abort_i = 0;
      req_i = req_in_done; addr_i = a;
      chk(busy_o === 1'b0, "R2", "busy_after", busy_o, 0);
      chk(done_o === !aborted, aborted ? "R6" : "R2", "done", done_o, !aborted);
      chk(err_o === (exp_err && !aborted), exp_err ? "R4" : "R3", "err", err_o,
          exp_err && !aborted);
      chk({bus_oe_o, bus_cs_o, bus_shs_o, cse_o} === 5'b0, "R7", "pins_off",
          {bus_oe_o, bus_cs_o, bus_shs_o, cse_o}, 0);
      @(posedge clk);
      @(negedge clk);
      req_i = 0;
      chk(done_o === 1'b0 && busy_o === 1'b0, "R9", "idle_after",
          {done_o, busy_o}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL WATCHDOG act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int idx;
      repeat (3) @(negedge clk);
      chk({busy_o, done_o, err_o, bus_oe_o, bus_cs_o, cse_o} === 7'b0, "R1", "reset",
          {busy_o, done_o, err_o, bus_oe_o, bus_cs_o, cse_o}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(busy_o === 1'b0, "R1", "idle_post_reset", busy_o, 0);

      // R2 R3 R4 R5: sweep of acknowledge arrival cycles against monitor limit
      idx = 0;
      for (int ta = 0; ta <= 3; ta++)
         for (int tea = 0; tea <= 3; tea++)
            for (int lim = 0; lim <= 4; lim++)
               for (int en = 0; en <= 1; en++) begin
                  run_one(16'(idx * 16'h0137), idx[0], 3'(idx), 2'(idx >> 1),
                          idx[1], idx[2], 1'b1, 1'b0, ta, tea, idx[0], idx[1],
                          lim, en[0], 0, idx[3]);
                  idx++;
               end

      // R5: longer limit with no response
      run_one(16'h8123, 1'b0, 3'd5, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, 0, 0,
              12, 1'b1, 0, 1'b0);

      // R6: abort placed before, on, and after the terminating cycle
      for (int ab = 1; ab <= 4; ab++)
         for (int e = 0; e <= 1; e++)
            run_one(16'hC010, 1'b1, 3'd2, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0,
                    e ? 0 : 3, e ? 3 : 0, 1'b0, 1'b1, 0, 1'b0, ab, 1'b1);

      // R8: address classes under every mode combination
      for (int m = 0; m < 4; m++) begin
         for (int i = 0; i < 64; i++)
            run_one(16'(i * 16'h0400 + m * 16'h0011), 1'b1, 3'd1, 2'd0, 1'b0, 1'b0,
                    m[0], m[1], 1, 0, 1'b1, 1'b0, 0, 1'b0, 0, 1'b0);
         for (int j = 0; j < 6; j++)
            run_one(16'hC03E + 16'(j), 1'b0, 3'd7, 2'd2, 1'b1, 1'b0, m[0], m[1],
                    1, 0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0);
         run_one(16'hCFFF, 1'b0, 3'd3, 2'd1, 1'b0, 1'b0, m[0], m[1], 2, 0, 1'b0,
                 1'b0, 0, 1'b0, 0, 1'b0);
         run_one(16'hD000, 1'b0, 3'd3, 2'd1, 1'b0, 1'b0, m[0], m[1], 2, 0, 1'b0,
                 1'b0, 0, 1'b0, 0, 1'b0);
         run_one(16'h7FFF, 1'b0, 3'd3, 2'd1, 1'b0, 1'b0, m[0], m[1], 2, 0, 1'b0,
                 1'b0, 0, 1'b0, 0, 1'b0);
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule